// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Hub

This block lets up to four cores interrupt one another. Each core issues commands through one shared port: an operation code, the issuing core's index, an argument index that names either a target or a sender, and a valid strobe. An external arbiter picks one issuer per cycle. The block keeps one pending bit for every sender-target pair and drives one interrupt line per core. A core can raise an interrupt toward another core, ask whether its own earlier interrupt to a target is still outstanding, ask which cores are interrupting it, and acknowledge each sender separately.

When several cores interrupt the same target, their requests merge onto that target's single line. The source query then returns a bitmask with one bit per sender. The target clears each sender with its own acknowledge. The line falls only after the last sender has been acknowledged. Query answers go into a readback register, which holds its value until the next query.

Top module: `ipi_hub`

## Requirements
- R1: After reset, every pending bit is clear, every interrupt line is low and the readback register reads zero.
- R2: A raise command (op code 2) from issuer s naming target t, with t different from s, sets the pending bit for pair s->t. The interrupt line of t is high from the cycle after the command.
- R3: A raise command whose target equals the issuing core changes no pending bit and no interrupt line.
- R4: A status query (op code 1) from issuer s naming target t loads the readback register with the s->t pending bit in bit 0 and zeros in every other bit.
- R5: A source query (op code 3) from issuer t loads the readback register with a mask in which bit n is set exactly when core n has an interrupt pending toward t.
- R6: When two or more cores have interrupts pending toward the same target, that target has one asserted line and the source query reports several set bits.
- R7: An acknowledge command (op code 4) from issuer t naming sender n clears only the n->t pending bit. The line of t stays high while any other bit toward t remains set, and it goes low in the cycle after the last acknowledge.
- R8: The readback register takes its new value one cycle after a query. It keeps that value through every non-query cycle: valid low, raise, acknowledge, or an unused op code (0, 5, 6, 7).
- R9: Raising an interrupt for a pair that is already pending leaves it pending. One acknowledge then clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for this cycle |
| cmd_op | input | 3 | Operation code (1 status, 2 raise, 3 source, 4 acknowledge) |
| cmd_src | input | 2 | Index of the issuing core |
| cmd_arg | input | 2 | Target index (status, raise) or sender index (acknowledge) |
| rdback | output | 4 | Readback register holding the last query result |
| irq_out | output | 4 | Interrupt line per core |

## Verification
A pending bit that is stuck, clears the wrong entry, or sits at the wrong sender-target position shows up on the target's interrupt line in the very next cycle. It also appears in the bitmask of the next source query, one cycle after that query is issued. Readback errors, whether from the wrong pair, an extra bit or a register that does not hold, are checked every cycle against a scoreboard value. The stimulus covers self-raises, duplicate raises, merged senders and partial acknowledges, so each of these corner states reaches both outputs.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int NCORE = 4;
    localparam int IDX_W = $clog2(NCORE);
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_STATUS = 3'd1,
        OP_RAISE  = 3'd2,
        OP_SOURCE = 3'd3,
        OP_ACK    = 3'd4
    } ipi_op_e;

    typedef struct packed {
        logic             valid;
        ipi_op_e          op;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] arg;
    } ipi_cmd_t;

    // pend[target][sender]
    typedef logic [NCORE-1:0][NCORE-1:0] pend_mat_t;

    function automatic logic is_query(ipi_cmd_t c);
        return c.valid && (c.op == OP_STATUS || c.op == OP_SOURCE);
    endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
(
    input  ipi_cmd_t  cmd,
    output pend_mat_t set_m,
    output pend_mat_t clr_m
);
    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (cmd.valid) begin
            case (cmd.op)
                OP_RAISE: if (cmd.arg != cmd.src) set_m[cmd.arg][cmd.src] = 1'b1;
                OP_ACK:   clr_m[cmd.src][cmd.arg] = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_mat_t        set_m,
    input  pend_mat_t        clr_m,
    output pend_mat_t        pend_q,
    output logic [NCORE-1:0] line
);
    for (genvar t = 0; t < NCORE; t++) begin : g_tgt
        for (genvar s = 0; s < NCORE; s++) begin : g_snd
            always_ff @(posedge clk) begin
                if (rst)              pend_q[t][s] <= 1'b0;
                else if (set_m[t][s]) pend_q[t][s] <= 1'b1;
                else if (clr_m[t][s]) pend_q[t][s] <= 1'b0;
            end

            assert_set_pair_R2: assert property (@(posedge clk) disable iff (rst)
                set_m[t][s] |=> pend_q[t][s]);
            assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
                (clr_m[t][s] && !set_m[t][s]) |=> !pend_q[t][s]);
            assert_hold_pair_R9: assert property (@(posedge clk) disable iff (rst)
                (!set_m[t][s] && !clr_m[t][s]) |=> $stable(pend_q[t][s]));
        end
        assign line[t] = |pend_q[t];
    end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ipi_cmd_t         cmd,
    input  pend_mat_t        pend_q,
    output logic [NCORE-1:0] rd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (cmd.valid && cmd.op == OP_STATUS) begin
            rd_q    <= '0;
            rd_q[0] <= pend_q[cmd.arg][cmd.src];
        end else if (cmd.valid && cmd.op == OP_SOURCE) begin
            rd_q <= pend_q[cmd.src];
        end
    end

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !is_query(cmd) |=> $stable(rd_q));
    assert_status_width_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.op == OP_STATUS) |=> (rd_q[NCORE-1:1] == '0));
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [IDX_W-1:0] cmd_src,
    input  logic [IDX_W-1:0] cmd_arg,
    output logic [NCORE-1:0] rdback,
    output logic [NCORE-1:0] irq_out
);
    ipi_cmd_t  cmd;
    pend_mat_t set_m, clr_m, pend_q;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = ipi_op_e'(cmd_op);
    assign cmd.src   = cmd_src;
    assign cmd.arg   = cmd_arg;

    ipi_decode u_dec (.cmd(cmd), .set_m(set_m), .clr_m(clr_m));

    ipi_pend_matrix u_mat (
        .clk(clk), .rst(rst), .set_m(set_m), .clr_m(clr_m),
        .pend_q(pend_q), .line(irq_out)
    );

    ipi_readback u_rb (
        .clk(clk), .rst(rst), .cmd(cmd), .pend_q(pend_q), .rd_q(rdback)
    );

    assert_self_noop_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RAISE && cmd_arg == cmd_src) |=> $stable(irq_out));
    assert_raise_line_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RAISE && cmd_arg != cmd_src) |=> irq_out[$past(cmd_arg)]);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (irq_out == '0 && rdback == '0));
endmodule

// File: tb/ipi_hub_tb_top.sv
`timescale 1ns/1ps
module ipi_hub_tb_top;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_src, cmd_arg;
    logic [N-1:0] rdback, irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [N-1:0] mp [N];    // model: mp[target][sender]
    logic [N-1:0] rd_model;
    logic [N-1:0] exp_q [$];
    string        tag_q [$];

    always #2.5 clk = ~clk;

    ipi_hub dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_arg(cmd_arg), .rdback(rdback), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: called at a negedge, returns at the next negedge
    task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] s,
                         input logic [1:0] a, input string tag);
        cmd_valid = v; cmd_op = op; cmd_src = s; cmd_arg = a;
        if (v && op == 3'd1) begin
            rd_model = '0; rd_model[0] = mp[a][s];
        end else if (v && op == 3'd3) begin
            rd_model = mp[s];
        end
        if (v && op == 3'd2 && a != s) mp[a][s] = 1'b1;
        if (v && op == 3'd4) mp[s][a] = 1'b0;
        exp_q.push_back(rd_model);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [N-1:0] model_lines();
        logic [N-1:0] r;
        for (int t = 0; t < N; t++) r[t] = |mp[t];
        return r;
    endfunction

    task automatic check_lines(input string tag);
        check(irq_out == model_lines(), tag, irq_out, model_lines());
    endtask

    // monitor: compares readback just after each edge that captured a command
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdback === e, t, rdback, e);
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < N; t++) mp[t] = '0;
        rd_model = '0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_src = '0; cmd_arg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(irq_out == '0 && rdback == '0, "R1 reset state", irq_out | rdback, '0);

        // R2: core 0 raises toward core 2
        issue(1, 3'd2, 2'd0, 2'd2, "R8 rd held on raise");
        check_lines("R2 raise asserts target line");
        // R4: status queries
        issue(1, 3'd1, 2'd0, 2'd2, "R4 status pending");
        issue(1, 3'd1, 2'd1, 2'd2, "R4 status not pending");
        // R3: self raise
        issue(1, 3'd2, 2'd3, 2'd3, "R8 rd held on self raise");
        check_lines("R3 self raise no line change");
        issue(1, 3'd3, 2'd3, 2'd0, "R3 self raise leaves source mask empty");
        // R6: coalescing toward core 2
        issue(1, 3'd2, 2'd1, 2'd2, "R8 rd held");
        issue(1, 3'd2, 2'd3, 2'd2, "R8 rd held");
        check_lines("R6 one line for several senders");
        issue(1, 3'd3, 2'd2, 2'd0, "R5 R6 source mask multi-bit");
        // R8: hold through idle and unused codes
        issue(0, 3'd3, 2'd0, 2'd0, "R8 rd held when valid low");
        issue(1, 3'd0, 2'd0, 2'd0, "R8 rd held on code 0");
        issue(1, 3'd5, 2'd2, 2'd1, "R8 rd held on code 5");
        issue(1, 3'd7, 2'd2, 2'd3, "R8 rd held on code 7");
        check_lines("R8 unused codes leave lines");
        // R7: partial acknowledges
        issue(1, 3'd4, 2'd2, 2'd1, "R8 rd held on ack");
        check_lines("R7 line stays after partial ack");
        issue(1, 3'd3, 2'd2, 2'd0, "R7 only acked sender cleared");
        issue(1, 3'd4, 2'd2, 2'd0, "R8 rd held on ack");
        check_lines("R7 line stays with last sender");
        issue(1, 3'd4, 2'd2, 2'd3, "R8 rd held on ack");
        check_lines("R7 line drops after last ack");
        issue(1, 3'd3, 2'd2, 2'd0, "R7 source mask empty after acks");
        // R9: duplicate raise
        issue(1, 3'd2, 2'd1, 2'd0, "R8 rd held");
        issue(1, 3'd2, 2'd1, 2'd0, "R8 rd held");
        issue(1, 3'd1, 2'd1, 2'd0, "R9 duplicate still pending");
        issue(1, 3'd4, 2'd0, 2'd1, "R8 rd held on ack");
        check_lines("R9 single ack clears duplicate");
        issue(1, 3'd1, 2'd1, 2'd0, "R9 status clear after one ack");
        // R5: per-target masks across all pairs
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++)
                if (((s + 2 * t) % 3) == 0)
                    issue(1, 3'd2, 2'(s), 2'(t), "R2 sweep raise");
        check_lines("R2 sweep lines");
        for (int t = 0; t < N; t++) issue(1, 3'd3, 2'(t), 2'd0, "R5 sweep source mask");
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++)
                issue(1, 3'd1, 2'(s), 2'(t), "R4 sweep status");
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                issue(1, 3'd4, 2'(t), 2'(s), "R7 sweep ack");
        check_lines("R7 all lines low after sweep");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule